// File: doc/BRIEF.md
# SIMT Divergence Reconvergence Stack

This block keeps the control-flow state of one warp of `LANES` threads that run in lockstep. It holds a small stack. Each entry names the PC the warp fetches next, the set of lanes that execute with it, and the PC at which those lanes rejoin their siblings. The fetch PC and the lane mask given to issue always come from the top entry.

When a branch resolves, the branch unit sends the taken target, the fall-through PC, the branch's rejoin PC (its immediate post-dominator) and one taken bit per lane. If every active lane goes the same way, only the top entry's PC moves. If the active lanes split, the top entry is parked at the rejoin PC with its full mask. The fall-through group is pushed next and the taken group last, so the taken side runs first. Each time the warp's next PC equals the top entry's rejoin PC, that entry is dropped and the exposed entry continues.

A launch pulse starts a warp. It leaves one entry holding the start PC, all lanes active and an all-ones rejoin PC. A PC of all ones is reserved, so that rejoin value never matches.

Top module: `simt_reconv_stack`

## Requirements
- R1: A cycle with `launch_valid` high leaves, from the next cycle, depth 1, `fetch_pc` equal to `launch_pc`, `fetch_mask` all ones, and both error flags clear. Launch takes priority over every other input in that cycle.
- R2: While depth is non-zero, `fetch_pc` and `fetch_mask` show the top entry's next PC and lane mask. At depth 0 both read zero.
- R3: For an accepted branch, the taken lanes are the top mask AND the taken bits, and the fall lanes are the top mask AND NOT the taken bits. If one of these groups is empty, depth is unchanged and the top PC becomes the taken target (no fall lanes) or the fall-through PC (no taken lanes).
- R4: If both groups are non-empty, the top entry's PC becomes the branch rejoin PC and its mask is kept. An entry {rejoin, fall-through PC, fall lanes} is pushed, then {rejoin, taken target, taken lanes}, so the taken group is on top. Depth grows by 2.
- R5: In a split, a group whose start PC equals the branch rejoin PC is not pushed, and depth grows only by the groups that are pushed. If neither is pushed, the rejoin PC is applied as in R6/R7.
- R6: If the applied next PC (from `pc_next`, or from a branch per R3/R5) equals the top entry's rejoin PC and depth is above 1, the top entry is popped. Fetch resumes from the exposed entry's PC and mask.
- R7: If the applied next PC does not match the top rejoin PC, only the top entry's PC is replaced.
- R8: A split whose pushes would take depth above `DEPTH` sets `overflow` and leaves the stack unchanged. The flag holds until the next launch, and depth never exceeds `DEPTH`.
- R9: A pop request at depth 1 (possible only with the reserved PC of all ones) sets `underflow` and leaves the stack unchanged. The flag holds until the next launch.
- R10: `br_ready` is high when depth is non-zero and `launch_valid` is low. `pc_ready` additionally requires `br_valid` low. An input with valid high and ready low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, leaves depth 0 |
| launch_valid | input | 1 | Start a warp this cycle |
| launch_pc | input | PC_W | Start PC for the warp |
| br_valid | input | 1 | Branch resolution offered |
| br_ready | output | 1 | Branch resolution accepted when high with br_valid |
| br_taken_pc | input | PC_W | Taken target |
| br_fall_pc | input | PC_W | Fall-through PC |
| br_rpc | input | PC_W | Rejoin PC of the branch |
| br_taken_bits | input | LANES | Per-lane taken outcome |
| pc_valid | input | 1 | Sequential next PC offered |
| pc_ready | output | 1 | Next PC accepted when high with pc_valid |
| pc_next | input | PC_W | Warp next PC |
| fetch_pc | output | PC_W | PC of the top entry |
| fetch_mask | output | LANES | Active lanes of the top entry |
| stack_depth | output | $clog2(DEPTH+1) | Number of live entries |
| overflow | output | 1 | Sticky: a split did not fit |
| underflow | output | 1 | Sticky: pop of the last entry was requested |

## Verification
The assertions assume two things about the inputs. First, a branch's rejoin PC is a real post-dominator, so the ordinary instruction stream never carries the reserved all-ones PC. Second, reset is held for at least one edge before any launch. The directed stimulus uses ordinary PCs and presents the all-ones PC only once, to provoke the underflow. The randomised stimulus draws every PC from a small set that excludes it. That random phase overlaps branch and next-PC offers and sends occasional launches, so the ready rules and launch priority are exercised against the reference model.

// File: rtl/simt_stack_pkg.sv
package simt_stack_pkg;
  localparam int NUM_WR_PORTS = 3;
  localparam int PORT_TOP     = 0;
  localparam int PORT_FALL    = 1;
  localparam int PORT_TAKEN   = 2;
endpackage

// File: rtl/simt_branch_split.sv
module simt_branch_split #(
  parameter int LANES = 4,
  parameter int PC_W  = 16
) (
  input  logic [LANES-1:0] top_mask,
  input  logic [LANES-1:0] taken_bits,
  input  logic [PC_W-1:0]  taken_pc,
  input  logic [PC_W-1:0]  fall_pc,
  input  logic [PC_W-1:0]  rejoin_pc,
  output logic [LANES-1:0] taken_lanes,
  output logic [LANES-1:0] fall_lanes,
  output logic             push_taken,
  output logic             push_fall,
  output logic             push_any,
  output logic [PC_W-1:0]  adv_pc
);
  logic split;

  always_comb begin
    taken_lanes = top_mask & taken_bits;
    fall_lanes  = top_mask & ~taken_bits;
    split       = (|taken_lanes) && (|fall_lanes);
    push_taken  = split && (taken_pc != rejoin_pc);
    push_fall   = split && (fall_pc != rejoin_pc);
    push_any    = push_taken || push_fall;
    if (split)             adv_pc = rejoin_pc;
    else if (|taken_lanes) adv_pc = taken_pc;
    else                   adv_pc = fall_pc;
  end
endmodule

// File: rtl/simt_stack_store.sv
module simt_stack_store #(
  parameter int LANES = 4,
  parameter int DEPTH = 8,
  parameter int PC_W  = 16,
  parameter int NWR   = 3,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NWR-1:0]              wr_en,
  input  logic [NWR-1:0][IDX_W-1:0]   wr_idx,
  input  logic [NWR-1:0][PC_W-1:0]    wr_rpc,
  input  logic [NWR-1:0][PC_W-1:0]    wr_pc,
  input  logic [NWR-1:0][LANES-1:0]   wr_mask,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic [PC_W-1:0]             rd_rpc,
  output logic [PC_W-1:0]             rd_pc,
  output logic [LANES-1:0]            rd_mask
);
  logic [PC_W-1:0]  ent_rpc  [DEPTH];
  logic [PC_W-1:0]  ent_pc   [DEPTH];
  logic [LANES-1:0] ent_mask [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_rpc[e]  <= '0;
        ent_pc[e]   <= '0;
        ent_mask[e] <= '0;
      end else begin
        for (int p = 0; p < NWR; p++) begin
          if (wr_en[p] && (wr_idx[p] == IDX_W'(e))) begin
            ent_rpc[e]  <= wr_rpc[p];
            ent_pc[e]   <= wr_pc[p];
            ent_mask[e] <= wr_mask[p];
          end
        end
      end
    end
  end

  assign rd_rpc  = ent_rpc[rd_idx];
  assign rd_pc   = ent_pc[rd_idx];
  assign rd_mask = ent_mask[rd_idx];
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import simt_stack_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 8,
  parameter int PC_W  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         launch_valid,
  input  logic [PC_W-1:0]              launch_pc,
  input  logic                         br_valid,
  output logic                         br_ready,
  input  logic [PC_W-1:0]              br_taken_pc,
  input  logic [PC_W-1:0]              br_fall_pc,
  input  logic [PC_W-1:0]              br_rpc,
  input  logic [LANES-1:0]             br_taken_bits,
  input  logic                         pc_valid,
  output logic                         pc_ready,
  input  logic [PC_W-1:0]              pc_next,
  output logic [PC_W-1:0]              fetch_pc,
  output logic [LANES-1:0]             fetch_mask,
  output logic [$clog2(DEPTH+1)-1:0]   stack_depth,
  output logic                         overflow,
  output logic                         underflow
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PC_W-1:0] NEVER_PC = '1;

  logic [CNT_W-1:0] count, count_n;
  logic             ovf_q, ovf_n, unf_q, unf_n;
  logic             live, br_fire, pc_fire;
  logic [IDX_W-1:0] top_idx, slot_fall, slot_taken;
  logic [CNT_W:0]   need_total;

  logic [NUM_WR_PORTS-1:0]            wr_en;
  logic [NUM_WR_PORTS-1:0][IDX_W-1:0] wr_idx;
  logic [NUM_WR_PORTS-1:0][PC_W-1:0]  wr_rpc;
  logic [NUM_WR_PORTS-1:0][PC_W-1:0]  wr_pc;
  logic [NUM_WR_PORTS-1:0][LANES-1:0] wr_mask;

  logic [PC_W-1:0]  rd_rpc, rd_pc;
  logic [LANES-1:0] rd_mask;

  logic [LANES-1:0] s_taken_lanes, s_fall_lanes;
  logic             s_push_taken, s_push_fall, s_push_any;
  logic [PC_W-1:0]  s_adv_pc;

  logic             do_adv;
  logic [PC_W-1:0]  sel_pc;

  assign live     = (count != '0);
  assign br_ready = live && !launch_valid;
  assign pc_ready = live && !launch_valid && !br_valid;
  assign br_fire  = br_valid && br_ready;
  assign pc_fire  = pc_valid && pc_ready;

  assign top_idx    = IDX_W'(count - CNT_W'(1));
  assign slot_fall  = IDX_W'(count);
  assign slot_taken = IDX_W'(count) + IDX_W'(s_push_fall);
  assign need_total = {1'b0, count} + (CNT_W+1)'(s_push_fall) + (CNT_W+1)'(s_push_taken);

  simt_branch_split #(.LANES(LANES), .PC_W(PC_W)) u_split (
    .top_mask    (rd_mask),
    .taken_bits  (br_taken_bits),
    .taken_pc    (br_taken_pc),
    .fall_pc     (br_fall_pc),
    .rejoin_pc   (br_rpc),
    .taken_lanes (s_taken_lanes),
    .fall_lanes  (s_fall_lanes),
    .push_taken  (s_push_taken),
    .push_fall   (s_push_fall),
    .push_any    (s_push_any),
    .adv_pc      (s_adv_pc)
  );

  simt_stack_store #(.LANES(LANES), .DEPTH(DEPTH), .PC_W(PC_W), .NWR(NUM_WR_PORTS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_rpc  (wr_rpc),
    .wr_pc   (wr_pc),
    .wr_mask (wr_mask),
    .rd_idx  (top_idx),
    .rd_rpc  (rd_rpc),
    .rd_pc   (rd_pc),
    .rd_mask (rd_mask)
  );

  always_comb begin
    wr_en   = '0;
    wr_idx  = '0;
    wr_rpc  = '0;
    wr_pc   = '0;
    wr_mask = '0;
    count_n = count;
    ovf_n   = ovf_q;
    unf_n   = unf_q;
    do_adv  = 1'b0;
    sel_pc  = pc_next;

    if (launch_valid) begin
      wr_en[PORT_TOP]   = 1'b1;
      wr_idx[PORT_TOP]  = '0;
      wr_rpc[PORT_TOP]  = NEVER_PC;
      wr_pc[PORT_TOP]   = launch_pc;
      wr_mask[PORT_TOP] = '1;
      count_n = CNT_W'(1);
      ovf_n   = 1'b0;
      unf_n   = 1'b0;
    end else if (br_fire) begin
      if (s_push_any) begin
        if (need_total > (CNT_W+1)'(DEPTH)) begin
          ovf_n = 1'b1;
        end else begin
          wr_en[PORT_TOP]     = 1'b1;
          wr_idx[PORT_TOP]    = top_idx;
          wr_rpc[PORT_TOP]    = rd_rpc;
          wr_pc[PORT_TOP]     = br_rpc;
          wr_mask[PORT_TOP]   = rd_mask;
          wr_en[PORT_FALL]    = s_push_fall;
          wr_idx[PORT_FALL]   = slot_fall;
          wr_rpc[PORT_FALL]   = br_rpc;
          wr_pc[PORT_FALL]    = br_fall_pc;
          wr_mask[PORT_FALL]  = s_fall_lanes;
          wr_en[PORT_TAKEN]   = s_push_taken;
          wr_idx[PORT_TAKEN]  = slot_taken;
          wr_rpc[PORT_TAKEN]  = br_rpc;
          wr_pc[PORT_TAKEN]   = br_taken_pc;
          wr_mask[PORT_TAKEN] = s_taken_lanes;
          count_n = need_total[CNT_W-1:0];
        end
      end else begin
        do_adv = 1'b1;
        sel_pc = s_adv_pc;
      end
    end else if (pc_fire) begin
      do_adv = 1'b1;
    end

    if (do_adv) begin
      if (sel_pc == rd_rpc) begin
        if (count == CNT_W'(1)) unf_n = 1'b1;
        else                    count_n = count - CNT_W'(1);
      end else begin
        wr_en[PORT_TOP]   = 1'b1;
        wr_idx[PORT_TOP]  = top_idx;
        wr_rpc[PORT_TOP]  = rd_rpc;
        wr_pc[PORT_TOP]   = sel_pc;
        wr_mask[PORT_TOP] = rd_mask;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      count <= count_n;
      ovf_q <= ovf_n;
      unf_q <= unf_n;
    end
  end

  assign fetch_pc    = live ? rd_pc : '0;
  assign fetch_mask  = live ? rd_mask : '0;
  assign stack_depth = count;
  assign overflow    = ovf_q;
  assign underflow   = unf_q;
endmodule

// File: rtl/simt_stack_checker.sv
module simt_stack_checker #(
  parameter int LANES = 4,
  parameter int DEPTH = 8,
  parameter int PC_W  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             launch_valid,
  input logic [PC_W-1:0]  launch_pc,
  input logic             br_fire,
  input logic             pc_fire,
  input logic [PC_W-1:0]  pc_next,
  input logic [PC_W-1:0]  top_rpc,
  input logic [LANES-1:0] top_mask,
  input logic [LANES-1:0] taken_lanes,
  input logic [LANES-1:0] fall_lanes,
  input logic             br_ready,
  input logic             pc_ready,
  input logic [CNT_W-1:0] stack_depth,
  input logic [PC_W-1:0]  fetch_pc,
  input logic [LANES-1:0] fetch_mask,
  input logic             overflow,
  input logic             underflow
);
  assert_launch_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    launch_valid |=> (stack_depth == CNT_W'(1)) && (fetch_mask == '1) &&
                     (fetch_pc == $past(launch_pc)) && !overflow && !underflow);

  assert_split_partition_R4: assert property (@(posedge clk) disable iff (!rst_n)
    br_fire |-> ((taken_lanes & fall_lanes) == '0) && ((taken_lanes | fall_lanes) == top_mask));

  assert_pop_on_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_fire && (pc_next == top_rpc) && (stack_depth > CNT_W'(1)))
      |=> (stack_depth == $past(stack_depth) - CNT_W'(1)));

  assert_depth_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stack_depth <= CNT_W'(DEPTH));

  assert_no_overflow_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !launch_valid) |=> overflow);

  assert_underflow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !launch_valid) |=> underflow);

  assert_idle_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_depth == '0) |-> (!br_ready && !pc_ready));

  assert_single_consumer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(br_fire && pc_fire));
endmodule

bind simt_reconv_stack simt_stack_checker #(.LANES(LANES), .DEPTH(DEPTH), .PC_W(PC_W)) u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .launch_valid (launch_valid),
  .launch_pc    (launch_pc),
  .br_fire      (br_fire),
  .pc_fire      (pc_fire),
  .pc_next      (pc_next),
  .top_rpc      (rd_rpc),
  .top_mask     (rd_mask),
  .taken_lanes  (s_taken_lanes),
  .fall_lanes   (s_fall_lanes),
  .br_ready     (br_ready),
  .pc_ready     (pc_ready),
  .stack_depth  (stack_depth),
  .fetch_pc     (fetch_pc),
  .fetch_mask   (fetch_mask),
  .overflow     (overflow),
  .underflow    (underflow)
);

// File: tb/simt_reconv_stack_bench.sv
`timescale 1ns/1ps
module simt_reconv_stack_bench;
  localparam int L     = 4;
  localparam int D     = 4;
  localparam int PW    = 16;
  localparam int CW    = $clog2(D + 1);
  localparam int FULL  = (1 << L) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          launch_valid = 1'b0;
  logic [PW-1:0] launch_pc = '0;
  logic          br_valid = 1'b0;
  logic          br_ready;
  logic [PW-1:0] br_taken_pc = '0, br_fall_pc = '0, br_rpc = '0;
  logic [L-1:0]  br_taken_bits = '0;
  logic          pc_valid = 1'b0;
  logic          pc_ready;
  logic [PW-1:0] pc_next = '0;
  logic [PW-1:0] fetch_pc;
  logic [L-1:0]  fetch_mask;
  logic [CW-1:0] stack_depth;
  logic          overflow, underflow;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  simt_reconv_stack #(.LANES(L), .DEPTH(D), .PC_W(PW)) u_simt_reconv_stack (
    .clk(clk), .rst_n(rst_n),
    .launch_valid(launch_valid), .launch_pc(launch_pc),
    .br_valid(br_valid), .br_ready(br_ready),
    .br_taken_pc(br_taken_pc), .br_fall_pc(br_fall_pc), .br_rpc(br_rpc),
    .br_taken_bits(br_taken_bits),
    .pc_valid(pc_valid), .pc_ready(pc_ready), .pc_next(pc_next),
    .fetch_pc(fetch_pc), .fetch_mask(fetch_mask), .stack_depth(stack_depth),
    .overflow(overflow), .underflow(underflow)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int q_rpc[$];
  int q_pc[$];
  int q_m[$];
  bit m_ovf = 0, m_unf = 0;

  task automatic m_adv(int p);
    if (q_rpc[q_rpc.size()-1] == p) begin
      if (q_rpc.size() == 1) m_unf = 1;
      else begin
        void'(q_rpc.pop_back()); void'(q_pc.pop_back()); void'(q_m.pop_back());
      end
    end else q_pc[q_pc.size()-1] = p;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q_rpc.delete(); q_pc.delete(); q_m.delete(); m_ovf = 0; m_unf = 0;
    end else if (launch_valid) begin
      q_rpc.delete(); q_pc.delete(); q_m.delete();
      q_rpc.push_back((1 << PW) - 1); q_pc.push_back(int'(launch_pc)); q_m.push_back(FULL);
      m_ovf = 0; m_unf = 0;
    end else if (q_pc.size() > 0 && br_valid) begin
      int top, t, f, pt, pf;
      top = q_m[q_m.size()-1];
      t = top & int'(br_taken_bits);
      f = top & ~int'(br_taken_bits) & FULL;
      if (t != 0 && f != 0) begin
        pf = (br_fall_pc != br_rpc) ? 1 : 0;
        pt = (br_taken_pc != br_rpc) ? 1 : 0;
        if (pf + pt == 0) m_adv(int'(br_rpc));
        else if (q_pc.size() + pf + pt > D) m_ovf = 1;
        else begin
          q_pc[q_pc.size()-1] = int'(br_rpc);
          if (pf == 1) begin q_rpc.push_back(int'(br_rpc)); q_pc.push_back(int'(br_fall_pc)); q_m.push_back(f); end
          if (pt == 1) begin q_rpc.push_back(int'(br_rpc)); q_pc.push_back(int'(br_taken_pc)); q_m.push_back(t); end
        end
      end else if (t != 0) m_adv(int'(br_taken_pc));
      else m_adv(int'(br_fall_pc));
    end else if (q_pc.size() > 0 && pc_valid) begin
      m_adv(int'(pc_next));
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n) begin
      int sz;
      sz = q_pc.size();
      chk("R2", "fetch_pc", int'(fetch_pc), sz > 0 ? q_pc[sz-1] : 0);
      chk("R2", "fetch_mask", int'(fetch_mask), sz > 0 ? q_m[sz-1] : 0);
      chk("R6", "depth", int'(stack_depth), sz);
      chk("R8", "overflow", int'(overflow), int'(m_ovf));
      chk("R9", "underflow", int'(underflow), int'(m_unf));
      chk("R10", "br_ready", int'(br_ready), int'(sz > 0 && !launch_valid));
      chk("R10", "pc_ready", int'(pc_ready), int'(sz > 0 && !launch_valid && !br_valid));
    end
  end

  // ---------------- drivers ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_launch(int pc);
    launch_valid = 1'b1; launch_pc = PW'(pc); tick(); launch_valid = 1'b0;
  endtask

  task automatic do_adv(int pc);
    pc_valid = 1'b1; pc_next = PW'(pc); tick(); pc_valid = 1'b0;
  endtask

  task automatic do_br(int bits, int tpc, int fpc, int rpc);
    br_valid = 1'b1; br_taken_bits = L'(bits);
    br_taken_pc = PW'(tpc); br_fall_pc = PW'(fpc); br_rpc = PW'(rpc);
    tick(); br_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R2", "idle depth", int'(stack_depth), 0);
    chk("R10", "idle br_ready", int'(br_ready), 0);
    do_adv('h55);                       // ignored while idle
    chk("R10", "idle pc ignored", int'(stack_depth), 0);

    do_launch('h100);
    chk("R1", "launch pc", int'(fetch_pc), 'h100);
    chk("R1", "launch mask", int'(fetch_mask), FULL);
    chk("R1", "launch depth", int'(stack_depth), 1);

    do_adv('h104);
    chk("R7", "advance pc", int'(fetch_pc), 'h104);

    pc_valid = 1'b1; pc_next = 'h222;   // branch wins, next PC ignored
    do_br('hF, 'h108, 'h10C, 'h400);
    pc_valid = 1'b0;
    chk("R10", "pc ignored under branch", int'(fetch_pc), 'h108);

    do_br('b0110, 'h200, 'h300, 'h400);
    chk("R4", "split depth", int'(stack_depth), 3);
    chk("R4", "taken on top pc", int'(fetch_pc), 'h200);
    chk("R4", "taken mask", int'(fetch_mask), 'b0110);
    do_adv('h204);
    do_adv('h400);
    chk("R6", "pop to fall pc", int'(fetch_pc), 'h300);
    chk("R6", "fall mask", int'(fetch_mask), 'b1001);
    do_adv('h400);
    chk("R6", "rejoined pc", int'(fetch_pc), 'h400);
    chk("R6", "rejoined mask", int'(fetch_mask), FULL);

    do_br('hF, 'h500, 'h404, 'h600);
    chk("R3", "uniform taken pc", int'(fetch_pc), 'h500);
    chk("R3", "uniform depth", int'(stack_depth), 1);
    do_br('h0, 'h580, 'h504, 'h600);
    chk("R3", "uniform fall pc", int'(fetch_pc), 'h504);

    do_br('b0011, 'h600, 'h700, 'h700);
    chk("R5", "one path pushed", int'(stack_depth), 2);
    chk("R5", "taken mask", int'(fetch_mask), 'b0011);
    do_adv('h700);
    chk("R5", "back to full", int'(fetch_mask), FULL);

    do_br('b0111, 'h800, 'h900, 'hA00);
    chk("R4", "depth before full", int'(stack_depth), 3);
    do_br('b0001, 'h810, 'h820, 'h830);
    chk("R8", "overflow flag", int'(overflow), 1);
    chk("R8", "stack kept", int'(stack_depth), 3);
    chk("R8", "pc kept", int'(fetch_pc), 'h800);
    do_adv('h804);
    chk("R8", "overflow sticky", int'(overflow), 1);

    do_launch('h40);
    chk("R1", "flags cleared", int'(overflow), 0);
    do_adv('hFFFF);
    chk("R9", "underflow flag", int'(underflow), 1);
    chk("R9", "depth kept", int'(stack_depth), 1);
    chk("R9", "pc kept", int'(fetch_pc), 'h40);

    do_launch('h10);
    for (int i = 0; i < 600; i++) begin
      int r;
      r = int'($urandom_range(0, 39));
      launch_valid  = (r == 0);
      launch_pc     = PW'('h10 * int'($urandom_range(1, 4)));
      br_valid      = (r % 3 == 1);
      pc_valid      = (r % 2 == 0);
      br_taken_bits = L'($urandom_range(0, FULL));
      br_taken_pc   = PW'('h10 * int'($urandom_range(1, 4)));
      br_fall_pc    = PW'('h10 * int'($urandom_range(1, 4)));
      br_rpc        = PW'('h10 * int'($urandom_range(1, 4)));
      pc_next       = PW'('h10 * int'($urandom_range(1, 4)));
      tick();
    end
    launch_valid = 1'b0; br_valid = 1'b0; pc_valid = 1'b0;
    tick();
    finish_run();
  end
endmodule